// File: doc/BRIEF.md
# Default Data Capability Access Checker

This block screens an ordinary (non-capability) memory access against the default data capability, which always sits in capability register 0. The requester supplies a 64-bit offset, an access kind (fetch, load or store) and a size code. The capability arrives already decoded: tag, sealed flag, three permission bits, base, a 65-bit top and a cursor. The block forms the virtual address as cursor plus offset. It then runs a fixed chain of checks: tag, then seal, then the permission that matches the access kind, then bounds. The first check that fails decides the fault cause.

The check logic is combinational. Its result is held in one output register stage that raises a valid flag one cycle after the request. Beside this path, a purely combinational gate reports whether a capability register index may be touched. Indices 27 to 31 are reserved for privileged use and need the system-access permission of the program-counter capability.

Top module: `ddc_access_checker`

## Requirements
- R1: `rsp_valid_o` is high in exactly the cycle after a clock edge that sampled `req_valid_i` high. The response fields then belong to that request. With no request, no response appears.
- R2: A request whose capability tag is clear faults with cause 8'h02. This holds whatever the seal, permission and bounds inputs are.
- R3: A tagged, sealed capability faults with cause 8'h03, whatever its permissions and bounds.
- R4: For a tagged, unsealed capability, each access kind needs its own permission. Kind 2'd0 (fetch) without execute gives cause 8'h11. Kind 2'd1 (load) without load gives 8'h12. Kind 2'd2 or 2'd3 (store) without store gives 8'h13. Permissions that belong to other kinds have no effect. A permission fault wins over a bounds fault.
- R5: The virtual address is cursor plus offset, modulo 2^64. A request that passes every check returns it on `rsp_vaddr_o` with `rsp_fault_o` low and cause 8'h00.
- R6: Size code n (2 bits) means 2^n bytes (1, 2, 4 or 8). If vaddr + size > top (65-bit compare) or vaddr < base, the result is cause 8'h01. An access that ends exactly at top passes, including a top of 2^64.
- R7: A fault response drives `rsp_fault_o` high and `rsp_vaddr_o` to zero. `rsp_regnum_o` is always 8'h00.
- R8: `reg_access_ok_o` is high for indices 0 to 26 in all cases. For indices 27 to 31 it equals `pcc_sys_access_i`. It is combinational and independent of the request path.
- R9: While `rst_ni` is low, `rsp_valid_o`, `rsp_fault_o`, `rsp_cause_o` and `rsp_vaddr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_offset_i | input | 64 | Address offset added to the cursor |
| req_kind_i | input | 2 | 0 fetch, 1 load, 2/3 store |
| req_size_i | input | 2 | log2 of access bytes |
| cap_tag_i | input | 1 | Capability valid tag |
| cap_sealed_i | input | 1 | Capability sealed |
| cap_perm_exec_i | input | 1 | Execute permission |
| cap_perm_load_i | input | 1 | Load permission |
| cap_perm_store_i | input | 1 | Store permission |
| cap_base_i | input | 64 | Lower bound |
| cap_top_i | input | 65 | Exclusive upper bound |
| cap_cursor_i | input | 64 | Capability address |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 1 | Access refused |
| rsp_cause_o | output | 8 | Fault cause code |
| rsp_regnum_o | output | 8 | Faulting capability register |
| rsp_vaddr_o | output | 64 | Checked virtual address |
| reg_idx_i | input | 5 | Capability register index to screen |
| pcc_sys_access_i | input | 1 | Program-counter capability grants system access |
| reg_access_ok_o | output | 1 | Register index accessible |

## Verification
The registered access verdict and the combinational register gate can both change in the same cycle. The bench drives a stream of back-to-back random requests and, in the same cycles, sweeps the register index through all 32 values with the system-access bit both low and high. It then checks the gate output a moment after each drive. The scoreboard compares the verdict for the request of the previous cycle. Neither result may disturb the other, and a miscompare on either side counts as a failure.

// File: rtl/ddc_chk_pkg.sv
package ddc_chk_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned CAUSE_W = 8;

  typedef enum logic [1:0] {
    ACC_FETCH     = 2'd0,
    ACC_LOAD      = 2'd1,
    ACC_STORE     = 2'd2,
    ACC_STORE_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [CAUSE_W-1:0] {
    FLT_NONE   = 8'h00,
    FLT_LENGTH = 8'h01,
    FLT_TAG    = 8'h02,
    FLT_SEAL   = 8'h03,
    FLT_EXEC   = 8'h11,
    FLT_LOAD   = 8'h12,
    FLT_STORE  = 8'h13
  } flt_cause_e;

  typedef struct packed {
    logic              fault;
    flt_cause_e        cause;
    logic [ADDR_W-1:0] vaddr;
  } chk_rsp_t;
endpackage

// File: rtl/ddc_addr_gen.sv
module ddc_addr_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SIZE_W = 2
) (
  input  logic [ADDR_W-1:0] cursor_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W:0]   top_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] vaddr_o,
  output logic              oob_o
);
  localparam int unsigned BYTES_W = (1 << SIZE_W) + 1;

  logic [BYTES_W-1:0] n_bytes;
  logic [ADDR_W:0]    end_addr;

  assign vaddr_o  = cursor_i + offset_i;
  assign n_bytes  = BYTES_W'(1) << size_i;
  // one extra bit keeps vaddr + 8 exact near 2^64
  assign end_addr = {1'b0, vaddr_o} + (ADDR_W+1)'(n_bytes);
  assign oob_o    = (end_addr > top_i) || (vaddr_o < base_i);
endmodule

// File: rtl/ddc_perm_check.sv
module ddc_perm_check
  import ddc_chk_pkg::*;
(
  input  logic       tag_i,
  input  logic       sealed_i,
  input  logic       perm_exec_i,
  input  logic       perm_load_i,
  input  logic       perm_store_i,
  input  acc_kind_e  kind_i,
  input  logic       oob_i,
  output logic       fault_o,
  output flt_cause_e cause_o
);
  logic perm_ok;
  flt_cause_e perm_cause;

  always_comb begin
    unique case (kind_i)
      ACC_FETCH: begin perm_ok = perm_exec_i; perm_cause = FLT_EXEC; end
      ACC_LOAD:  begin perm_ok = perm_load_i; perm_cause = FLT_LOAD; end
      default:   begin perm_ok = perm_store_i; perm_cause = FLT_STORE; end
    endcase
  end

  // fixed priority: tag, seal, permission, bounds
  always_comb begin
    if (!tag_i)        cause_o = FLT_TAG;
    else if (sealed_i) cause_o = FLT_SEAL;
    else if (!perm_ok) cause_o = perm_cause;
    else if (oob_i)    cause_o = FLT_LENGTH;
    else               cause_o = FLT_NONE;
  end

  assign fault_o = (cause_o != FLT_NONE);

  // R2
  always_comb begin
    untagged_cause_chk: assert (tag_i || cause_o == FLT_TAG);
  end
endmodule

// File: rtl/ddc_sysreg_gate.sv
module ddc_sysreg_gate #(
  parameter int unsigned REG_IDX_W  = 5,
  parameter int unsigned SYS_REG_LO = 27
) (
  input  logic [REG_IDX_W-1:0] idx_i,
  input  logic                 sys_access_i,
  output logic                 ok_o
);
  localparam int unsigned N_REGS = 1 << REG_IDX_W;

  generate
    if (SYS_REG_LO >= N_REGS) begin : g_no_sys
      assign ok_o = 1'b1;
    end else begin : g_sys
      localparam logic [REG_IDX_W-1:0] LO = REG_IDX_W'(SYS_REG_LO);
      assign ok_o = (idx_i < LO) || sys_access_i;
    end
  endgenerate

  // R8
  always_comb begin
    low_reg_open_chk: assert (!(int'(idx_i) < SYS_REG_LO) || ok_o);
  end
endmodule

// File: rtl/ddc_rsp_reg.sv
module ddc_rsp_reg
  import ddc_chk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  input  chk_rsp_t rsp_i,
  output logic     valid_o,
  output chk_rsp_t rsp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      rsp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) rsp_o <= rsp_i;
    end
  end
endmodule

// File: rtl/ddc_access_checker.sv
module ddc_access_checker
  import ddc_chk_pkg::*;
#(
  parameter int unsigned REG_IDX_W  = 5,
  parameter int unsigned SYS_REG_LO = 27,
  parameter int unsigned SIZE_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_offset_i,
  input  logic [1:0]           req_kind_i,
  input  logic [SIZE_W-1:0]    req_size_i,
  input  logic                 cap_tag_i,
  input  logic                 cap_sealed_i,
  input  logic                 cap_perm_exec_i,
  input  logic                 cap_perm_load_i,
  input  logic                 cap_perm_store_i,
  input  logic [ADDR_W-1:0]    cap_base_i,
  input  logic [ADDR_W:0]      cap_top_i,
  input  logic [ADDR_W-1:0]    cap_cursor_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_fault_o,
  output logic [CAUSE_W-1:0]   rsp_cause_o,
  output logic [CAUSE_W-1:0]   rsp_regnum_o,
  output logic [ADDR_W-1:0]    rsp_vaddr_o,
  input  logic [REG_IDX_W-1:0] reg_idx_i,
  input  logic                 pcc_sys_access_i,
  output logic                 reg_access_ok_o
);
  localparam logic [CAUSE_W-1:0] DDC_REGNUM = '0;

  logic [ADDR_W-1:0] vaddr;
  logic              oob;
  logic              fault;
  flt_cause_e        cause;
  chk_rsp_t          rsp_d, rsp_q;

  ddc_addr_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_addr (
    .cursor_i (cap_cursor_i),
    .offset_i (req_offset_i),
    .base_i   (cap_base_i),
    .top_i    (cap_top_i),
    .size_i   (req_size_i),
    .vaddr_o  (vaddr),
    .oob_o    (oob)
  );

  ddc_perm_check u_perm (
    .tag_i        (cap_tag_i),
    .sealed_i     (cap_sealed_i),
    .perm_exec_i  (cap_perm_exec_i),
    .perm_load_i  (cap_perm_load_i),
    .perm_store_i (cap_perm_store_i),
    .kind_i       (acc_kind_e'(req_kind_i)),
    .oob_i        (oob),
    .fault_o      (fault),
    .cause_o      (cause)
  );

  assign rsp_d.fault = fault;
  assign rsp_d.cause = cause;
  assign rsp_d.vaddr = fault ? '0 : vaddr;

  ddc_rsp_reg u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (req_valid_i),
    .rsp_i   (rsp_d),
    .valid_o (rsp_valid_o),
    .rsp_o   (rsp_q)
  );

  assign rsp_fault_o  = rsp_q.fault;
  assign rsp_cause_o  = rsp_q.cause;
  assign rsp_vaddr_o  = rsp_q.vaddr;
  assign rsp_regnum_o = DDC_REGNUM;

  ddc_sysreg_gate #(.REG_IDX_W(REG_IDX_W), .SYS_REG_LO(SYS_REG_LO)) u_gate (
    .idx_i        (reg_idx_i),
    .sys_access_i (pcc_sys_access_i),
    .ok_o         (reg_access_ok_o)
  );

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R2
  tag_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !cap_tag_i) |=> (rsp_fault_o && rsp_cause_o == 8'h02));
  // R3
  seal_second_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cap_tag_i && cap_sealed_i) |=> (rsp_cause_o == 8'h03));
  // R7
  fault_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_vaddr_o == '0 && rsp_regnum_o == '0));
  // R5
  pass_no_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_cause_o == 8'h00));
endmodule

// File: tb/ddc_access_checker_tb.sv
`timescale 1ns/1ps
module ddc_access_checker_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_offset;
  logic [1:0]  req_kind;
  logic [1:0]  req_size;
  logic        c_tag, c_sealed, c_px, c_pl, c_ps;
  logic [63:0] c_base, c_cursor;
  logic [64:0] c_top;
  logic        rsp_valid, rsp_fault;
  logic [7:0]  rsp_cause, rsp_regnum;
  logic [63:0] rsp_vaddr;
  logic [4:0]  reg_idx;
  logic        sys_acc, reg_ok;

  ddc_access_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .req_offset_i(req_offset), .req_kind_i(req_kind), .req_size_i(req_size),
    .cap_tag_i(c_tag), .cap_sealed_i(c_sealed), .cap_perm_exec_i(c_px),
    .cap_perm_load_i(c_pl), .cap_perm_store_i(c_ps), .cap_base_i(c_base),
    .cap_top_i(c_top), .cap_cursor_i(c_cursor), .rsp_valid_o(rsp_valid),
    .rsp_fault_o(rsp_fault), .rsp_cause_o(rsp_cause), .rsp_regnum_o(rsp_regnum),
    .rsp_vaddr_o(rsp_vaddr), .reg_idx_i(reg_idx), .pcc_sys_access_i(sys_acc),
    .reg_access_ok_o(reg_ok)
  );

  typedef struct {
    logic tag, sealed, px, pl, ps;
    logic [1:0] kind, size;
    logic [63:0] off, base, cur;
    logic [64:0] top;
  } req_t;

  typedef struct packed {
    logic fault; logic [7:0] cause; logic [63:0] vaddr;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic exp_t model(req_t r);
    exp_t e;
    logic [63:0] va;
    logic [64:0] endv;
    logic [7:0] c;
    va   = r.cur + r.off;
    endv = {1'b0, va} + 65'(9'd1 << r.size);
    if (!r.tag) c = 8'h02;
    else if (r.sealed) c = 8'h03;
    else if (r.kind == 2'd0 && !r.px) c = 8'h11;
    else if (r.kind == 2'd1 && !r.pl) c = 8'h12;
    else if (r.kind[1] && !r.ps) c = 8'h13;
    else if (endv > r.top || va < r.base) c = 8'h01;
    else c = 8'h00;
    e.fault = (c != 8'h00);
    e.cause = c;
    e.vaddr = e.fault ? 64'h0 : va;
    return e;
  endfunction

  function automatic req_t good();
    req_t r;
    r.tag = 1; r.sealed = 0; r.px = 1; r.pl = 1; r.ps = 1;
    r.kind = 2'd1; r.size = 2'd3; r.off = 64'h10;
    r.base = 64'h1000; r.cur = 64'h1000; r.top = 65'h2000;
    return r;
  endfunction

  task automatic apply(string rq, req_t r);
    @(negedge clk);
    req_valid = 1; req_offset = r.off; req_kind = r.kind; req_size = r.size;
    c_tag = r.tag; c_sealed = r.sealed; c_px = r.px; c_pl = r.pl; c_ps = r.ps;
    c_base = r.base; c_cursor = r.cur; c_top = r.top;
    exp_q.push_back(model(r));
    tag_q.push_back(rq);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done && rsp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_fault !== e.fault || rsp_cause !== e.cause ||
            rsp_vaddr !== e.vaddr || rsp_regnum !== 8'h00) begin
          n_bad++;
          $display("FAIL %s R7: actual f=%0b c=%h va=%h rn=%h expected f=%0b c=%h va=%h rn=00",
                   t, rsp_fault, rsp_cause, rsp_vaddr, rsp_regnum, e.fault, e.cause, e.vaddr);
        end
      end
    end
  end

  task automatic check(string rq, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    req_t r;
    rst_n = 0; req_valid = 0; req_offset = 0; req_kind = 0; req_size = 0;
    c_tag = 0; c_sealed = 0; c_px = 0; c_pl = 0; c_ps = 0;
    c_base = 0; c_cursor = 0; c_top = 0; reg_idx = 0; sys_acc = 0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(rsp_valid), 64'h0);
    check("R9 reset fault/cause", {55'h0, rsp_fault, rsp_cause}, 64'h0);
    check("R9 reset vaddr", rsp_vaddr, 64'h0);
    rst_n = 1;

    r = good(); r.tag = 0; r.sealed = 1; r.px = 0; r.pl = 0; r.ps = 0; r.off = 64'h5000;
    apply("R2 untagged beats all", r);
    r = good(); r.sealed = 1; r.pl = 0; r.off = 64'h5000;
    apply("R3 sealed", r);
    r = good(); r.kind = 2'd0; r.px = 0;
    apply("R4 fetch no exec", r);
    r = good(); r.pl = 0;
    apply("R4 load no load", r);
    r = good(); r.kind = 2'd2; r.ps = 0;
    apply("R4 store no store", r);
    r = good(); r.kind = 2'd3; r.ps = 0;
    apply("R4 kind3 store no store", r);
    r = good(); r.px = 0; r.ps = 0;
    apply("R4 foreign perms ignored", r);
    r = good(); r.kind = 2'd2; r.ps = 0; r.off = 64'h9000;
    apply("R4 perm before bounds", r);
    r = good();
    apply("R5 pass", r);
    r = good(); r.off = 64'hFF8;
    apply("R6 exact fit", r);
    r = good(); r.off = 64'hFF9;
    apply("R6 one past top", r);
    r = good(); r.off = 64'hFFFF_FFFF_FFFF_FFFF;
    apply("R6 below base via wrap R5", r);
    r = good(); r.size = 2'd0; r.off = 64'hFFF;
    apply("R6 byte at last", r);
    r = good(); r.size = 2'd1; r.off = 64'hFFF;
    apply("R6 half past top", r);
    r = good(); r.base = 0; r.cur = 0; r.top = 65'h1_0000_0000_0000_0000;
    r.off = 64'hFFFF_FFFF_FFFF_FFF8;
    apply("R6 top 2^64 fit", r);
    r.off = 64'hFFFF_FFFF_FFFF_FFF9;
    apply("R6 top 2^64 overrun", r);
    r = good(); r.cur = 64'hFFFF_FFFF_FFFF_FFF0; r.off = 64'h1020; r.base = 0;
    apply("R5 cursor wrap", r);
    idle();
    idle();
    check("R1 no response when idle", 64'(rsp_valid), 64'h0);

    for (int i = 0; i < 64; i++) begin
      r.tag = ($urandom % 8) != 0; r.sealed = ($urandom % 8) == 0;
      r.px = $urandom % 2; r.pl = ($urandom % 4) != 0; r.ps = ($urandom % 4) != 0;
      r.kind = 2'($urandom); r.size = 2'($urandom);
      r.base = 64'h4000 + 64'($urandom % 64); r.top = 65'h4100 + 65'($urandom % 64);
      r.cur = 64'h4000; r.off = 64'($urandom % 320);
      apply("R8/R1 concurrent stream", r);
      reg_idx = 5'(i % 32); sys_acc = (i >= 32);
      #1;
      check("R8 register gate", 64'(reg_ok), 64'((i % 32) < 27 || i >= 32));
    end
    idle();
    repeat (3) @(negedge clk);
    check("R1 all responses seen", 64'(exp_q.size()), 64'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule